// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block derives the bit timing of an I2C master from a fast system clock. A programmable divisor sets how many system clocks each internal phase lasts. One SCL period is cut into five phases, so the data change, the SCL rise, the read sample and the SCL fall each get a slot of their own. Phases 0 and 1 hold SCL low, and SDA may change in phase 0. Phases 2 to 4 release SCL, and the read sample belongs to phase 3.

Phase 2 also carries a fixed eight-clock allowance for the input synchroniser and the edge filter. A full SCL period therefore lasts 5*(divisor+1)+8 system clocks. For a wanted bus rate the divisor is ((ceil(f_clk/f_scl) - 8) / 5) - 1, with integer division. At a 133 MHz clock this gives 263 for 100 kHz and 64 for 400 kHz.

While phase 2 is active the sampled SCL line may read low because another device holds the clock. In that case the count freezes until the line reads high. Taking the enable low or raising the soft reset parks the sequence in phase 0 and releases SCL.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset with enable low, phase_idx is 0, phase_tick is 0 and scl_release is 1.
- R2: Phases 0, 1, 3 and 4 each last divisor+1 system clocks.
- R3: Phase 2 lasts divisor+9 system clocks when SCL is not stretched, so a full SCL period lasts 5*(divisor+1)+8 clocks.
- R4: phase_idx steps 0,1,2,3,4,0 in turn. phase_tick is high for exactly the first clock of each new phase and never at any other time.
- R5: When enabled, scl_release is 0 (SCL driven low) in phases 0 and 1, and 1 (released) in phases 2, 3 and 4.
- R6: Each clock during phase 2 in which scl_in reads 0 freezes the count, which lengthens phase 2 by one clock. scl_in has no effect in any other phase.
- R7: With enable at 0 or soft_rst at 1, scl_release is 1 at once, and from the next clock on phase_idx is 0 and phase_tick is 0. Once the block is running again, the first tick (entry into phase 1) comes divisor+1 clocks after the first active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the phase sequence when high |
| soft_rst | input | 1 | Synchronous restart to phase 0, has priority over enable |
| divisor | input | DIV_W | Phase length minus one, in system clocks |
| scl_in | input | 1 | Synchronised SCL line level |
| phase_tick | output | 1 | One-clock strobe on the first clock of each phase |
| phase_idx | output | 3 | Current phase, 0 to 4 |
| scl_release | output | 1 | 1 releases SCL, 0 requests it driven low |

## Verification
The assertions assume that rst_n is low for at least one edge. The length checks also assume that the divisor stays constant while the block is enabled and that scl_in reads low only when SCL is driven low or stretched. The bench therefore changes the divisor only while the block is disabled, and it builds scl_in as scl_release gated by a bench-controlled pull-down. That pull-down is applied only in phase 2, for a random number of clocks. Random divisors and stretch lengths are mixed with the extremes: divisor 0, divisor at its maximum, and the values computed for 100 kHz and 400 kHz.

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int DIV_W    = 12,
  parameter int EDGE_OVH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             soft_rst,
  input  logic [DIV_W-1:0] divisor,
  input  logic             scl_in,
  output logic             phase_tick,
  output logic [2:0]       phase_idx,
  output logic             scl_release
);
  localparam int CNT_W = DIV_W + $clog2(EDGE_OVH + 1) + 1;
  localparam logic [2:0] LAST_PH = 3'd4;
  localparam logic [2:0] RISE_PH = 3'd2;

  logic [CNT_W-1:0] cnt, limit;
  logic run, hold, adv;

  assign run   = enable & ~soft_rst;
  assign limit = CNT_W'(divisor) + ((phase_idx == RISE_PH) ? CNT_W'(EDGE_OVH) : '0);
  assign hold  = (phase_idx == RISE_PH) & ~scl_in;
  assign adv   = run & ~hold & (cnt >= limit);
  assign scl_release = ~run | (phase_idx >= RISE_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      phase_idx  <= '0;
      phase_tick <= 1'b0;
    end else if (!run) begin
      cnt        <= '0;
      phase_idx  <= '0;
      phase_tick <= 1'b0;
    end else begin
      phase_tick <= adv;
      if (adv) begin
        cnt       <= '0;
        phase_idx <= (phase_idx == LAST_PH) ? 3'd0 : phase_idx + 3'd1;
      end else if (!hold) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: each tick marks a single step of the phase ring
  a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase_tick |-> (phase_idx == (($past(phase_idx) == LAST_PH) ? 3'd0 : $past(phase_idx) + 3'd1)));

  // R4: a running phase change always comes with a tick
  a_r4_change_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && phase_idx != $past(phase_idx)) |-> phase_tick);

  // R4: phase index stays in range
  a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase_idx <= LAST_PH);

  // R5: SCL driven low in the first two phases
  a_r5_low_early: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase_idx < RISE_PH) |-> !scl_release);

  // R6: a stretched SCL blocks leaving phase 2
  a_r6_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase_idx == RISE_PH && !scl_in) |=> (!phase_tick && (phase_idx == RISE_PH || phase_idx == 3'd0)));

  // R7: stopping parks the sequencer and releases SCL
  a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_idx == 3'd0 && !phase_tick));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> scl_release);
endmodule

// File: tb/scl_phase_gen_tb_top.sv
`timescale 1ns/1ps
module scl_phase_gen_tb_top;
  localparam int DIV_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic soft_rst = 1'b0;
  logic [DIV_W-1:0] divisor = '0;
  logic pull = 1'b0;
  logic scl_in, phase_tick, scl_release;
  logic [2:0] phase_idx;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign scl_in = scl_release & ~pull;

  scl_phase_gen #(.DIV_W(DIV_W), .EDGE_OVH(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .divisor(divisor), .scl_in(scl_in), .phase_tick(phase_tick),
    .phase_idx(phase_idx), .scl_release(scl_release));

  function automatic int exp_len(int d, int ph, int st);
    return (ph == 2) ? d + 9 + st : d + 1;
  endfunction

  function automatic int exp_rel(int ph);
    return (ph >= 2) ? 1 : 0;
  endfunction

  function automatic int calc_div(longint fclk, longint fscl);
    return int'(((fclk + fscl - 1) / fscl - 8) / 5 - 1);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run_period(int d, int st);
    int n, len, held, total;
    enable = 1'b0; pull = 1'b0;
    @(negedge clk);
    divisor = DIV_W'(d);
    enable = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!phase_tick && n < 70000);
    check(n == d + 1, "R7 restart", n, d + 1);
    check(phase_idx == 3'd1, "R4 first step", phase_idx, 1);
    total = 0;
    for (int k = 0; k < 5; k++) begin
      automatic int ph = phase_idx;
      check(scl_release == exp_rel(ph), "R5 scl level", scl_release, exp_rel(ph));
      len = 1; held = 0;
      forever begin
        if (ph == 2 && held < st) begin pull = 1'b1; held++; end
        else pull = 1'b0;
        @(negedge clk);
        if (phase_tick || len > 70000) break;
        len++;
      end
      pull = 1'b0;
      total += len;
      if (ph == 2) check(len == exp_len(d, ph, st), (st > 0) ? "R6 stretch" : "R3 rise phase", len, exp_len(d, ph, st));
      else check(len == exp_len(d, ph, st), "R2 phase length", len, exp_len(d, ph, st));
      check(phase_idx == 3'((ph + 1) % 5), "R4 step", phase_idx, (ph + 1) % 5);
    end
    check(total == 5 * (d + 1) + 8 + st, "R3 period", total, 5 * (d + 1) + 8 + st);
  endtask

  task automatic stop_check(bit use_srst);
    repeat (3) @(negedge clk);
    if (use_srst) soft_rst = 1'b1; else enable = 1'b0;
    #1 check(scl_release == 1'b1, "R7 release", scl_release, 1);
    @(negedge clk);
    check(phase_idx == 3'd0 && !phase_tick, "R7 park", phase_idx, 0);
    repeat (4) @(negedge clk);
    check(phase_idx == 3'd0 && !phase_tick && scl_release, "R7 stays parked", phase_idx, 0);
    soft_rst = 1'b0; enable = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(phase_idx == 3'd0, "R1 phase", phase_idx, 0);
    check(phase_tick == 1'b0, "R1 tick", phase_tick, 0);
    check(scl_release == 1'b1, "R1 scl", scl_release, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(phase_idx == 3'd0 && !phase_tick && scl_release, "R1 idle after reset", phase_idx, 0);
    run_period(0, 0);
    run_period(0, 3);
    run_period(calc_div(133000000, 100000), 0);
    run_period(calc_div(133000000, 400000), 5);
    check(calc_div(133000000, 100000) == 263, "R3 divisor 100k", calc_div(133000000, 100000), 263);
    run_period(4, 0);
    stop_check(1'b0);
    run_period(7, 2);
    stop_check(1'b1);
    for (int i = 0; i < 30; i++) begin
      automatic int d = $urandom_range(0, 20);
      automatic int s = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 15);
      run_period(d, s);
      if (i % 7 == 3) stop_check(i % 2 == 1);
    end
    // R6: pulling SCL low outside phase 2 has no effect on phase length
    begin
      int n;
      enable = 1'b0; @(negedge clk);
      divisor = 12'd3; enable = 1'b1; pull = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!phase_tick && n < 100);
      pull = 1'b0;
      check(n == 4, "R6 ignored in phase 0", n, 4);
    end
    run_period((1 << DIV_W) - 1, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule